// File: doc/BRIEF.md
# Flash Protected Range Checker

This block screens every flash access against six programmable protected windows before the flash sequencer is allowed to start a cycle. Each window is described by one 32-bit configuration word. The word holds a first and a last 4 KiB block number and two independent enables: one that blocks reads and one that blocks writes and erases. A window with neither enable set has no effect. The final window is meant for general-purpose use, but its logic is the same as the others.

The sequencer presents a query, made of a start byte address, a byte count minus one and a direction, with a one-cycle `q_valid` strobe. On the next cycle the block answers with `r_valid`, a per-window hit mask and `r_acc_err`. The sequencer raises its access-error status from `r_acc_err` and drops the cycle. Results are produced every cycle and cannot be held back: there is no ready signal on either side, and the consumer must take each result in the cycle it is shown. A single `lock_i` input freezes the configuration once firmware has set it up.

Top module: `prc_prot_check`

## Requirements
- R1: After reset every window word is zero, so no access is denied, and `r_valid`, `r_hit` and `r_acc_err` are low.
- R2: A window word decodes as follows: first block in bits 13:0, read-block enable in bit 15, last block in bits 29:16, write-block enable in bit 31. Bits 14 and 30 are ignored.
- R3: A window covers byte addresses from first×4096 up to and including last×4096 + 0xFFF. A single byte just below or just above that span is not denied.
- R4: A read (`q_write`=0) hits a window only if the window's read-block enable is set. A write or erase (`q_write`=1) hits a window only if its write-block enable is set.
- R5: A window with both enables clear never hits, whatever its block numbers.
- R6: An access covers bytes `q_addr` through `q_addr + q_len_m1`. If that end passes the top of the address space, it is clipped to the last address. The access hits a window if any byte in it falls inside the window.
- R7: A window whose first block is greater than its last block is empty and never hits.
- R8: While `lock_i` is high, configuration writes are ignored.
- R9: `r_valid` is `q_valid` delayed by one clock. `r_hit[i]` is set when window i was hit by that query. `r_acc_err` is set when any window was hit. Both `r_hit` and `r_acc_err` are zero whenever `r_valid` is low.
- R10: A configuration write and a query presented in the same cycle: the query is judged against the windows as they stood before that write.
- R11: A configuration write whose `cfg_idx` is 6 or more changes no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | High blocks all configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Window number to write |
| cfg_wdata | input | 32 | Window word |
| q_valid | input | 1 | Query strobe |
| q_addr | input | 26 | Start byte address |
| q_len_m1 | input | 17 | Byte count minus one |
| q_write | input | 1 | 1 for write or erase, 0 for read |
| r_valid | output | 1 | Result strobe, one cycle after the query |
| r_hit | output | 6 | Windows that denied the query |
| r_acc_err | output | 1 | Access denied |

## Verification
The assertions assume that `lock_i`, `cfg_we` and `q_valid` are driven to known values from reset onward. They also assume that only the write port changes the window words, so a locked write must leave the configuration stable on the next cycle. The stimulus changes every input on the falling edge only. It keeps `cfg_idx` within its 3-bit field, including the values 6 and 7. It draws window bounds and addresses from a small region so that random queries often straddle window edges, and it asserts lock for about a tenth of the writes.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int WORD_W  = 32;
  localparam int FLD_W   = 14;
  localparam int BLK_SH  = 12;
  localparam int FIRST_LSB = 0;
  localparam int RDEN_BIT  = 15;
  localparam int LAST_LSB  = 16;
  localparam int WREN_BIT  = 31;

  typedef struct packed {
    logic             wr_blk;
    logic             rd_blk;
    logic [FLD_W-1:0] last;
    logic [FLD_W-1:0] first;
  } window_t;

  function automatic window_t decode_word(input logic [WORD_W-1:0] w);
    window_t r;
    r.first  = w[FIRST_LSB +: FLD_W];
    r.last   = w[LAST_LSB +: FLD_W];
    r.rd_blk = w[RDEN_BIT];
    r.wr_blk = w[WREN_BIT];
    return r;
  endfunction
endpackage

// File: rtl/prc_window_regs.sv
module prc_window_regs
  import prc_pkg::*;
#(
  parameter int NWIN  = 6,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lock_i,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic [WORD_W-1:0]    cfg_wdata,
  output window_t [NWIN-1:0]   win_q
);
  logic    wr_ok;
  window_t wr_dec;

  assign wr_ok  = cfg_we && !lock_i;
  assign wr_dec = decode_word(cfg_wdata);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        win_q[i] <= '0;
      else if (wr_ok && (int'(cfg_idx) == i))
        win_q[i] <= wr_dec;
    end
  end
endmodule

// File: rtl/prc_window_match.sv
module prc_window_match
  import prc_pkg::*;
(
  input  window_t          win,
  input  logic [FLD_W-1:0] blk_lo,
  input  logic [FLD_W-1:0] blk_hi,
  input  logic             is_write,
  output logic             hit
);
  logic enabled, nonempty, overlap;

  always_comb begin
    enabled  = is_write ? win.wr_blk : win.rd_blk;
    nonempty = win.first <= win.last;
    overlap  = (blk_lo <= win.last) && (blk_hi >= win.first);
    hit      = enabled && nonempty && overlap;
  end
endmodule

// File: rtl/prc_prot_check.sv
module prc_prot_check
  import prc_pkg::*;
#(
  parameter int NWIN   = 6,
  parameter int IDX_W  = 3,
  parameter int ADDR_W = 26,
  parameter int LEN_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              q_valid,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [LEN_W-1:0]  q_len_m1,
  input  logic              q_write,
  output logic              r_valid,
  output logic [NWIN-1:0]   r_hit,
  output logic              r_acc_err
);
  localparam int BLK_W = ADDR_W - BLK_SH;

  window_t [NWIN-1:0] win_q;
  logic [ADDR_W:0]    end_sum;
  logic [ADDR_W-1:0]  end_addr;
  logic [FLD_W-1:0]   blk_lo, blk_hi;
  logic [NWIN-1:0]    hit_c;

  prc_window_regs #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .win_q(win_q)
  );

  always_comb begin
    end_sum  = {1'b0, q_addr} + (ADDR_W+1)'(q_len_m1);
    end_addr = end_sum[ADDR_W] ? '1 : end_sum[ADDR_W-1:0];
    blk_lo   = FLD_W'(q_addr[ADDR_W-1:BLK_SH]);
    blk_hi   = FLD_W'(end_addr[ADDR_W-1:BLK_SH]);
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_match
    prc_window_match u_m (
      .win(win_q[i]), .blk_lo(blk_lo), .blk_hi(blk_hi),
      .is_write(q_write), .hit(hit_c[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_valid   <= 1'b0;
      r_hit     <= '0;
      r_acc_err <= 1'b0;
    end else begin
      r_valid   <= q_valid;
      r_hit     <= q_valid ? hit_c : '0;
      r_acc_err <= q_valid && (|hit_c);
    end
  end

  logic unused_blk;
  assign unused_blk = ^{BLK_W[0]};
endmodule

// File: rtl/prc_prot_check_sva.sv
module prc_prot_check_sva
  import prc_pkg::*;
#(
  parameter int NWIN = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lock_i,
  input logic               cfg_we,
  input logic               q_valid,
  input logic               r_valid,
  input logic [NWIN-1:0]    r_hit,
  input logic               r_acc_err,
  input window_t [NWIN-1:0] win_q
);
  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r_valid); // R9
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !r_valid); // R9
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !r_valid |-> (r_hit == '0) && !r_acc_err); // R9
  AST_ERR_MATCHES_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    r_acc_err == (r_hit != '0)); // R9
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && lock_i) |=> $stable(win_q)); // R8
  AST_IDLE_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(win_q)); // R8
endmodule

bind prc_prot_check prc_prot_check_sva #(.NWIN(NWIN)) u_sva (
  .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we(cfg_we),
  .q_valid(q_valid), .r_valid(r_valid), .r_hit(r_hit),
  .r_acc_err(r_acc_err), .win_q(win_q)
);

// File: tb/sim_prc_prot_check.sv
module sim_prc_prot_check;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lock_i = 0, cfg_we = 0, q_valid = 0, q_write = 0;
  logic [2:0]  cfg_idx = 0;
  logic [31:0] cfg_wdata = 0;
  logic [25:0] q_addr = 0;
  logic [16:0] q_len_m1 = 0;
  logic        r_valid, r_acc_err;
  logic [5:0]  r_hit;

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] model [6];
  bit          pend = 0, pend_v = 0;
  logic [5:0]  pend_hit = 0;
  string       pend_tag = "";
  bit          pw_en = 0;
  int          pw_idx = 0;
  logic [31:0] pw_data = 0;

  always #10 clk = ~clk;

  prc_prot_check u0 (.clk(clk), .rst_n(rst_n), .lock_i(lock_i), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .q_valid(q_valid), .q_addr(q_addr),
    .q_len_m1(q_len_m1), .q_write(q_write), .r_valid(r_valid), .r_hit(r_hit),
    .r_acc_err(r_acc_err));

  function automatic logic [5:0] ref_hit(input logic [25:0] a, input logic [16:0] l,
                                         input bit wr);
    logic [5:0] h = 0;
    longint e = longint'(a) + longint'(l);
    longint fb, lb;
    if (e > 64'h3FF_FFFF) e = 64'h3FF_FFFF;
    fb = longint'(a) >> 12;
    lb = e >> 12;
    for (int i = 0; i < 6; i++) begin
      longint b = model[i][13:0];
      longint t = model[i][29:16];
      bit en = wr ? model[i][31] : model[i][15];
      h[i] = en && (b <= t) && (fb <= t) && (lb >= b);
    end
    return h;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input int idx, input logic [31:0] d, input bit lk,
                      input bit qv, input logic [25:0] a, input logic [16:0] l,
                      input bit wr, input string tag);
    @(negedge clk);
    if (pend) begin
      chk({tag, "/R9 valid"}, r_valid, pend_v);
      chk({pend_tag, " hit"}, r_hit, pend_hit);
      chk({pend_tag, " err"}, r_acc_err, |pend_hit);
    end
    if (pw_en && pw_idx < 6) model[pw_idx] = pw_data;
    pw_en = we && !lk; pw_idx = idx; pw_data = d;
    cfg_we = we; cfg_idx = 3'(idx); cfg_wdata = d; lock_i = lk;
    q_valid = qv; q_addr = a; q_len_m1 = l; q_write = wr;
    pend = 1; pend_v = qv;
    pend_hit = qv ? ref_hit(a, l, wr) : 6'h0;
    pend_tag = tag;
  endtask

  task automatic cfg(input int idx, input logic [31:0] d, input bit lk, input string tag);
    step(1, idx, d, lk, 0, 0, 0, 0, tag);
  endtask

  task automatic qry(input logic [25:0] a, input logic [16:0] l, input bit wr,
                     input string tag, input logic [5:0] want);
    step(0, 0, 0, 0, 1, a, l, wr, tag);
    chk({tag, " spec"}, 32'(pend_hit), 32'(want));
  endtask

  function automatic logic [31:0] word(input int f, input int t, input bit rd, input bit wr);
    return {wr, 1'b0, 14'(t), rd, 1'b0, 14'(f)};
  endfunction

  initial begin
    for (int i = 0; i < 6; i++) model[i] = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", r_valid, 0);
    chk("R1 reset hit", r_hit, 0);
    rst_n = 1;
    qry(26'h0, 17'h1FFFF, 1, "R1 no window after reset", 6'h00);
    cfg(0, word(2, 3, 1, 0), 0, "R2 program w0");
    qry(26'h2000, 0, 0, "R3 first byte", 6'h01);
    qry(26'h1FFF, 0, 0, "R3 below span", 6'h00);
    qry(26'h3FFF, 0, 0, "R3 last byte", 6'h01);
    qry(26'h4000, 0, 0, "R3 above span", 6'h00);
    qry(26'h2000, 0, 1, "R4 write ignores read enable", 6'h00);
    qry(26'h1FFF, 1, 0, "R6 straddle into span", 6'h01);
    cfg(1, word(0, 16'h3FFF, 0, 0), 0, "R5 program disabled w1");
    qry(26'h12345, 0, 1, "R5 disabled window", 6'h00);
    cfg(2, word(5, 4, 1, 1), 0, "R7 program inverted w2");
    qry(26'h4000, 17'h2000, 1, "R7 inverted window", 6'h00);
    cfg(3, word(0, 16'h3FFF, 0, 1) | 32'h4000_4000, 1, "R8 locked write");
    qry(26'h100, 0, 1, "R8 lock ignored", 6'h00);
    cfg(7, word(0, 16'h3FFF, 1, 1), 0, "R11 out of range index");
    qry(26'h100, 0, 1, "R11 no window changed", 6'h00);
    step(1, 4, word(0, 0, 1, 0), 0, 1, 26'h10, 0, 0, "R10 same cycle query");
    chk("R10 spec", 32'(pend_hit), 0);
    qry(26'h10, 0, 0, "R10 next query sees write", 6'h10);
    cfg(5, word(16'h3FFF, 16'h3FFF, 0, 1) | 32'h4000_4000, 0, "R2 w5 top block");
    qry(26'h3FF_FFF0, 17'h100, 1, "R6 clipped end", 6'h20);
    qry(26'h3FF_E000, 17'h1FFF, 1, "R6 wide write", 6'h20);
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 10;
      if (r < 3) begin
        int b = $urandom % 64;
        logic [31:0] w = word(b, b + ($urandom % 10) - 2, $urandom % 2, $urandom % 2);
        step(1, $urandom % 8, w, ($urandom % 10) == 0, $urandom % 2,
             26'($urandom % (70 * 4096)), 17'($urandom % 20000), $urandom % 2, "R4 random");
      end else
        step(0, 0, 0, 0, r != 9, 26'($urandom % (70 * 4096)),
             17'((r < 6) ? $urandom % 64 : $urandom % 70000), $urandom % 2, "R6 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 flush");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule